// File: doc/BRIEF.md
# AC-link Reset and Slot-0 Tag Controller

This block is the register-mapped reset and tag front end of an AC97-style AC-link host. A simple word-addressed register bus reaches two registers: a control register and a slot-0 tag register. The control register drives the codec's active-low reset line, which is held for as long as software keeps the request set. It can also start a warm reset, and it holds the flag that tells the frame shifter a tag word is waiting.

A warm reset forces the frame sync line high for a fixed number of system clocks. That count is derived from the clock frequency, so that the pulse lasts at least the required minimum time. When the count runs out, the warm request bit clears itself. Outside a warm reset, the sync line follows an external frame-timing input that comes from the bit-clock logic.

The tag register holds the frame-valid flag and the four slot-valid flags that the frame shifter sends in slot 0. Software sets the pending flag to hand the tag to the shifter. The shifter clears the flag with a done pulse. While the flag is set, writes to the tag register are dropped without any effect.

Top module: `aclink_rst_tag_ctl`

## Requirements
- R1: After system reset, `codec_rst_n` is 1 and `sync_out` equals `frame_sync_in`. Both registers read 0 and `tag_pending` is 0.
- R2: Control bit 1 is the cold request and is read/write. One cycle after a control write, `codec_rst_n` equals the inverse of the written bit 1.
- R3: A control write with bit 2 = 1 while no warm reset is active starts one. From the next cycle, `sync_out` is 1 whatever `frame_sync_in` does, and bit 2 reads 1.
- R4: A warm reset lasts exactly W cycles, where W = ceil(CLK_HZ*MIN_NS/1e9). After that, bit 2 reads 0 and `sync_out` follows `frame_sync_in` again.
- R5: During a warm reset, control writes leave bit 2 and the remaining duration unchanged. Writing 0 does not abort it, and writing 1 does not restart it.
- R6: In the control register, bit 0 and bits 31:4 always read 0.
- R7: In the tag register, bit 4 is the frame-valid flag and bits 3:0 are the slot-valid flags. A write stores wdata[4:0], which then appear on `tag_word` and read back. Bits 31:5 read 0.
- R8: While `tag_pending` (control bit 3) is 1, writes to the tag register are ignored.
- R9: Writing 1 to control bit 3 sets `tag_pending`; writing 0 to it has no effect. A `shift_done` pulse clears the flag. If a set and a clear arrive in the same cycle, the set wins.
- R10: Addresses other than CTL_ADDR (0) and TAG_ADDR (1) read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| frame_sync_in | input | 1 | Sync from the frame-timing logic |
| shift_done | input | 1 | Frame shifter has taken the tag |
| codec_rst_n | output | 1 | Active-low codec cold reset |
| sync_out | output | 1 | Frame sync to the codec |
| tag_word | output | 5 | Slot-0 frame-valid and slot-valid flags |
| tag_pending | output | 1 | Tag waiting for the shifter |

## Verification
The bench builds two instances at a 100 MHz nominal frequency. One uses MIN_NS = 30, giving W = 3. The other uses MIN_NS = 41, which rounds up to W = 5. The short counts make it practical to check every cycle of a warm pulse against a toggling frame-timing input, and the second instance exercises the ceiling rounding. The five-bit tag field is small enough that all 32 values are written and read back exhaustively.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int CTL_COLD_BIT = 1;
  localparam int CTL_WARM_BIT = 2;
  localparam int CTL_FIN_BIT  = 3;
  localparam int TAG_W        = 5;

  typedef struct packed {
    logic fin;
    logic warm;
    logic cold;
  } ctl_bits_t;
endpackage

// File: rtl/aclink_ctl_regs.sv
module aclink_ctl_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_we,
  input  logic wr_cold,
  input  logic wr_fin,
  input  logic shift_done,
  output logic cold_q,
  output logic fin_q
);
  logic cold_d, fin_d, cold_en, fin_en;

  always_comb begin
    cold_en = ctl_we;
    cold_d  = wr_cold;
    fin_en  = (ctl_we && wr_fin) || shift_done;
    fin_d   = ctl_we && wr_fin;   // R9: set beats clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cold_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      if (cold_en) cold_q <= cold_d;
      if (fin_en)  fin_q  <= fin_d;
    end
  end
endmodule

// File: rtl/aclink_warm_timer.sv
module aclink_warm_timer #(
  parameter int WARM_CYCLES = 2500,
  localparam int CNT_W = (WARM_CYCLES < 2) ? 1 : $clog2(WARM_CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  output logic warm_q
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(WARM_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic warm_d, cnt_en;

  always_comb begin
    warm_d = warm_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!warm_q) begin
      if (start_req) begin
        warm_d = 1'b1;
        cnt_d  = LOAD;
        cnt_en = 1'b1;
      end
    end else if (cnt_q == '0) begin
      warm_d = 1'b0;
    end else begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      warm_q <= warm_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/aclink_tag_reg.sv
module aclink_tag_reg #(
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tag_we,
  input  logic             fin_q,
  input  logic [TAG_W-1:0] wr_tag,
  output logic [TAG_W-1:0] tag_q
);
  logic tag_en;

  always_comb tag_en = tag_we && !fin_q;   // R8

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tag_q <= '0;
    else if (tag_en) tag_q <= wr_tag;
  end
endmodule

// File: rtl/aclink_rst_tag_ctl.sv
module aclink_rst_tag_ctl
  import aclink_pkg::*;
#(
  parameter int     ADDR_W   = 4,
  parameter int     DATA_W   = 32,
  parameter int     CTL_ADDR = 0,
  parameter int     TAG_ADDR = 1,
  parameter longint CLK_HZ   = 250_000_000,
  parameter longint MIN_NS   = 10_000,
  localparam int    WARM_CYCLES = int'((CLK_HZ * MIN_NS + 64'd999_999_999) / 64'd1_000_000_000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              frame_sync_in,
  input  logic              shift_done,
  output logic              codec_rst_n,
  output logic              sync_out,
  output logic [TAG_W-1:0]  tag_word,
  output logic              tag_pending
);
  logic      ctl_sel, tag_sel, ctl_we, tag_we;
  ctl_bits_t ctl;
  logic      unused_wdata;

  always_comb begin
    ctl_sel = (reg_addr == ADDR_W'(CTL_ADDR));
    tag_sel = (reg_addr == ADDR_W'(TAG_ADDR));
    ctl_we  = reg_wr && ctl_sel;
    tag_we  = reg_wr && tag_sel;
  end

  assign unused_wdata = ^{reg_wdata[DATA_W-1:TAG_W], reg_wdata[0]};

  aclink_ctl_regs u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_we     (ctl_we),
    .wr_cold    (reg_wdata[CTL_COLD_BIT]),
    .wr_fin     (reg_wdata[CTL_FIN_BIT]),
    .shift_done (shift_done),
    .cold_q     (ctl.cold),
    .fin_q      (ctl.fin)
  );

  aclink_warm_timer #(.WARM_CYCLES(WARM_CYCLES)) u_warm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (ctl_we && reg_wdata[CTL_WARM_BIT]),
    .warm_q    (ctl.warm)
  );

  aclink_tag_reg #(.TAG_W(TAG_W)) u_tag (
    .clk    (clk),
    .rst_n  (rst_n),
    .tag_we (tag_we),
    .fin_q  (ctl.fin),
    .wr_tag (reg_wdata[TAG_W-1:0]),
    .tag_q  (tag_word)
  );

  always_comb begin
    codec_rst_n = !ctl.cold;
    sync_out    = ctl.warm ? 1'b1 : frame_sync_in;
    tag_pending = ctl.fin;
  end

  always_comb begin
    reg_rdata = '0;
    if (ctl_sel) begin
      reg_rdata[CTL_COLD_BIT] = ctl.cold;
      reg_rdata[CTL_WARM_BIT] = ctl.warm;
      reg_rdata[CTL_FIN_BIT]  = ctl.fin;
    end else if (tag_sel) begin
      reg_rdata[TAG_W-1:0] = tag_word;
    end
  end
endmodule

// File: rtl/aclink_rst_tag_chk.sv
module aclink_rst_tag_chk #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int CTL_ADDR    = 0,
  parameter int TAG_ADDR    = 1,
  parameter int WARM_CYCLES = 2500
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              shift_done,
  input logic              codec_rst_n,
  input logic              sync_out,
  input logic [4:0]        tag_word,
  input logic              tag_pending,
  input logic              warm_q
);
  int run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= 0;
    else if (warm_q) run_len <= run_len + 1;
    else run_len <= 0;
  end

  AST_COLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(CTL_ADDR)) |=> (codec_rst_n == !$past(reg_wdata[1]))); // R2

  AST_WARM_SYNC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    warm_q |-> sync_out); // R3

  AST_WARM_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    warm_q |-> (run_len < WARM_CYCLES)); // R4

  AST_WARM_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(warm_q) |-> (run_len == WARM_CYCLES)); // R4

  AST_TAG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(TAG_ADDR) && tag_pending) |=> $stable(tag_word)); // R8

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_done && !(reg_wr && reg_addr == ADDR_W'(CTL_ADDR) && reg_wdata[3])) |=> !tag_pending); // R9

  AST_CTL_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(CTL_ADDR)) |-> (reg_rdata[0] == 1'b0 && reg_rdata[DATA_W-1:4] == '0)); // R6
endmodule

bind aclink_rst_tag_ctl aclink_rst_tag_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_ADDR(CTL_ADDR),
  .TAG_ADDR(TAG_ADDR), .WARM_CYCLES(WARM_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .shift_done(shift_done),
  .codec_rst_n(codec_rst_n), .sync_out(sync_out), .tag_word(tag_word),
  .tag_pending(tag_pending), .warm_q(ctl.warm)
);

// File: tb/sim_aclink_rst_tag_ctl.sv
module sim_aclink_rst_tag_ctl;
  localparam longint HZ  = 100_000_000;
  localparam longint NS0 = 30;
  localparam longint NS1 = 41;
  localparam int W0 = int'((HZ * NS0 + 64'd999_999_999) / 64'd1_000_000_000);
  localparam int W1 = int'((HZ * NS1 + 64'd999_999_999) / 64'd1_000_000_000);

  logic        clk, rst_n, reg_wr, frame_sync_in, shift_done;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, rdata0, rdata1;
  logic        crst0, crst1, sync0, sync1, pend0, pend1;
  logic [4:0]  tag0, tag1;
  int checks, fails;
  bit done;

  aclink_rst_tag_ctl #(.CLK_HZ(HZ), .MIN_NS(NS0)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata0), .frame_sync_in(frame_sync_in),
    .shift_done(shift_done), .codec_rst_n(crst0), .sync_out(sync0),
    .tag_word(tag0), .tag_pending(pend0));

  aclink_rst_tag_ctl #(.CLK_HZ(HZ), .MIN_NS(NS1)) u1 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata1), .frame_sync_in(frame_sync_in),
    .shift_done(shift_done), .codec_rst_n(crst1), .sync_out(sync1),
    .tag_word(tag1), .tag_pending(pend1));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd0(input logic [3:0] a, input logic [31:0] exp, input string req);
    reg_addr = a;
    #0.5;
    check(rdata0, exp, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    frame_sync_in = 1'b0; shift_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check({31'd0, crst0}, 32'd1, "R1");
    check({31'd0, pend0}, 32'd0, "R1");
    frame_sync_in = 1'b1; #0.5;
    check({31'd0, sync0}, 32'd1, "R1");
    frame_sync_in = 1'b0; #0.5;
    check({31'd0, sync0}, 32'd0, "R1");
    rd0(4'd0, 32'd0, "R1");
    rd0(4'd1, 32'd0, "R1");

    // R2 cold request set and clear
    wr(4'd0, 32'h2);
    check({31'd0, crst0}, 32'd0, "R2");
    rd0(4'd0, 32'h2, "R2");
    wr(4'd0, 32'h0);
    check({31'd0, crst0}, 32'd1, "R2");
    rd0(4'd0, 32'h0, "R2");

    // R3 R4: warm pulse, both instances, sync must ignore toggling input
    wr(4'd0, 32'h4);
    for (int i = 0; i < W1 + 2; i++) begin
      frame_sync_in = i[0]; #0.5;
      check({31'd0, sync0}, (i < W0) ? 32'd1 : {31'd0, frame_sync_in}, i < W0 ? "R3" : "R4");
      check({31'd0, sync1}, (i < W1) ? 32'd1 : {31'd0, frame_sync_in}, "R4");
      rd0(4'd0, (i < W0) ? 32'h4 : 32'h0, "R4");
      @(negedge clk);
    end
    frame_sync_in = 1'b0;

    // R5: write 0 mid-pulse does not abort; write 1 mid-pulse does not restart
    wr(4'd0, 32'h4);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h0;
    @(negedge clk);
    reg_wdata = 32'h4;
    @(negedge clk);
    reg_wr = 1'b0;
    // three edges since start: W0=3 pulse has ended
    check({31'd0, sync0}, 32'd0, "R5");
    check({31'd0, sync1}, 32'd1, "R5");
    rd0(4'd0, 32'h0, "R5");

    // R6: all-ones control write, reserved bits stay 0
    repeat (W1) @(negedge clk);
    wr(4'd0, 32'hFFFF_FFFF);
    rd0(4'd0, 32'hE, "R6");
    check({31'd0, crst0}, 32'd0, "R2");
    // clear pending and cold, let warm finish
    @(negedge clk); shift_done = 1'b1;
    @(negedge clk); shift_done = 1'b0;
    wr(4'd0, 32'h0);
    repeat (W1) @(negedge clk);
    rd0(4'd0, 32'h0, "R6");

    // R7: exhaustive tag sweep with reserved bits set in the write
    for (int v = 0; v < 32; v++) begin
      wr(4'd1, {27'h7FF_FFFF, v[4:0]});
      check({27'd0, tag0}, {27'd0, v[4:0]}, "R7");
      rd0(4'd1, {27'd0, v[4:0]}, "R7");
    end

    // R8 R9: pending flag blocks tag writes
    wr(4'd1, 32'h0A);
    wr(4'd0, 32'h8);
    check({31'd0, pend0}, 32'd1, "R9");
    wr(4'd1, 32'h15);
    check({27'd0, tag0}, 32'h0A, "R8");
    rd0(4'd1, 32'h0A, "R8");
    wr(4'd0, 32'h0);
    check({31'd0, pend0}, 32'd1, "R9");
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h8; shift_done = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; shift_done = 1'b0;
    check({31'd0, pend0}, 32'd1, "R9");
    shift_done = 1'b1;
    @(negedge clk);
    shift_done = 1'b0;
    check({31'd0, pend0}, 32'd0, "R9");
    wr(4'd1, 32'h15);
    check({27'd0, tag0}, 32'h15, "R8");

    // R10: unmapped addresses
    for (int a = 2; a < 16; a++) begin
      wr(a[3:0], 32'hFFFF_FFFF);
      rd0(a[3:0], 32'h0, "R10");
    end
    rd0(4'd0, 32'h0, "R10");
    rd0(4'd1, 32'h15, "R10");
    check({31'd0, crst0}, 32'd1, "R10");
    check({31'd0, sync0}, {31'd0, frame_sync_in}, "R10");

    finish_run();
  end
endmodule